// File: doc/BRIEF.md
# Smart Card Receive Character Queue

This block sits behind the character receiver of an ISO 7816 card interface and keeps received characters in a small queue until the host reads them. The usable depth of the queue is set by a 3-bit length field, from one to eight entries. A character that arrives while the queue is already at its set depth is thrown away, and a sticky overrun flag is raised.

Parity errors are handled according to the selected transmission protocol. In character mode (T=0) the card repeats a character that arrived with bad parity. That character is therefore discarded and counted. A sticky parity flag rises when the count reaches a programmable 3-bit threshold. The same flag also rises when the card rejects a character that this side sent. In block mode (T=1) a character with bad parity is queued like any other, and the error counter stays idle. A single clear strobe, given when the host reads status, drops both flags and zeroes the error count.

Top module: `sc_rx_fifo`

## Requirements
- R1: After synchronous reset the queue is empty (`not_empty`=0, `full`=0) and both `pe_flag` and `ovr_flag` are 0.
- R2: Stored characters are read in arrival order. `rd_data` changes on the clock edge that samples `rd_en`. A read while the queue is empty leaves `rd_data` and the fill state unchanged.
- R3: The usable depth is `len_sel`+1. `full` rises, one edge after the store, when that many characters are held.
- R4: A character that is to be stored while `full` is 1 is discarded without disturbing the queue contents, and `ovr_flag` is set. A character that is dropped for parity does not set `ovr_flag`.
- R5: With `proto_t1`=0, a character with `rx_perr`=1 is not stored.
- R6: With `proto_t1`=0, `pe_flag` sets on the parity-errored character that brings the error count to `pe_thresh`. A `pe_thresh` of 0 stands for 8.
- R7: `tx_nak`=1 sets `pe_flag` when `proto_t1`=0 and is ignored when `proto_t1`=1.
- R8: With `proto_t1`=1, a character with `rx_perr`=1 is stored, and parity errors never raise `pe_flag`.
- R9: `stat_clr` clears `pe_flag`, `ovr_flag` and the error count. A flag-setting event in the same cycle takes priority over the clear.
- R10: Any change of `proto_t1` clears the error count.
- R11: `pe_flag` and `ovr_flag` stay set until `stat_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error on the received character |
| tx_nak | input | 1 | Card rejected a transmitted character |
| proto_t1 | input | 1 | 0 = T=0 character mode, 1 = T=1 block mode |
| pe_thresh | input | 3 | Parity error threshold (0 means 8) |
| len_sel | input | 3 | Queue depth minus one |
| rd_en | input | 1 | Read one character |
| stat_clr | input | 1 | Clear flags and error count |
| rd_data | output | 8 | Character read |
| pe_flag | output | 1 | Parity error flag |
| ovr_flag | output | 1 | Overrun flag |
| full | output | 1 | Queue at its set depth |
| not_empty | output | 1 | Queue holds at least one character |

## Verification
The assertions assume that `len_sel` is not lowered while the queue holds more characters than the new depth. They also assume that `stat_clr` does not arrive in the same cycle as a flag-setting event. The stimulus changes `len_sel` and `proto_t1` only while the queue is empty and between characters. It also keeps every clear strobe apart from character strobes and rejections. Each character is a single-cycle strobe, and reads are issued only while the bench's model still expects queued data, apart from one deliberate read of an empty queue.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  localparam int unsigned CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;

  typedef enum logic {
    PROTO_T0 = 1'b0,
    PROTO_T1 = 1'b1
  } proto_e;
endpackage

// File: rtl/sc_rx_mem.sv
module sc_rx_mem #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl #(
  parameter int AW = 3,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop_req,
  input  logic [LW-1:0] len_sel,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic          rd_go,
  output logic [AW-1:0] raddr,
  output logic          ovr_evt,
  output logic          full_q,
  output logic          ne_q
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nxt, depth;

  assign wr_en   = push && !full_q;
  assign ovr_evt = push && full_q;
  assign rd_go   = pop_req && ne_q;
  assign waddr   = wptr;
  assign raddr   = rptr;
  assign depth   = CW'(len_sel) + CW'(1);

  always_comb begin
    cnt_nxt = cnt;
    if (wr_en) cnt_nxt = cnt_nxt + CW'(1);
    if (rd_go) cnt_nxt = cnt_nxt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      full_q <= 1'b0;
      ne_q   <= 1'b0;
    end else begin
      if (wr_en) wptr <= wptr + AW'(1);
      if (rd_go) rptr <= rptr + AW'(1);
      cnt    <= cnt_nxt;
      full_q <= (cnt_nxt >= depth);
      ne_q   <= (cnt_nxt != '0);
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R2
  store_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_go) |=> (cnt == $past(cnt) + CW'(1)));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_evt && !pop_req) |=> $stable(wptr));
endmodule

// File: rtl/sc_rx_perr.sv
module sc_rx_perr #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          proto_t1,
  input  logic          rx_valid,
  input  logic          rx_perr,
  input  logic          tx_nak,
  input  logic [TW-1:0] thresh,
  input  logic          clr,
  output logic          pe_q
);
  localparam int EW = TW + 1;

  logic          proto_q;
  logic [EW-1:0] err_cnt, target;
  logic          mode_chg, cnt_en, hit, nak_hit;

  assign mode_chg = (proto_t1 != proto_q);
  assign target   = (thresh == '0) ? EW'(1 << TW) : EW'(thresh);
  assign cnt_en   = !proto_t1 && rx_valid && rx_perr && (err_cnt < target);
  assign hit      = cnt_en && ((err_cnt + EW'(1)) == target);
  assign nak_hit  = !proto_t1 && tx_nak;

  always_ff @(posedge clk) begin
    if (rst) begin
      proto_q <= 1'b0;
      err_cnt <= '0;
      pe_q    <= 1'b0;
    end else begin
      proto_q <= proto_t1;
      if (clr || mode_chg) err_cnt <= '0;
      else if (cnt_en)     err_cnt <= err_cnt + EW'(1);
      if (hit || nak_hit) pe_q <= 1'b1;
      else if (clr)       pe_q <= 1'b0;
    end
  end

  // R8
  t1_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (proto_t1 && proto_q) |=> (err_cnt == $past(err_cnt) || err_cnt == '0));

  // R7
  nak_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_nak && !proto_t1) |=> pe_q);

  // R11
  pe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pe_q && !clr) |=> pe_q);
endmodule

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
  parameter int AW = 3,
  parameter int LW = 3,
  parameter int TW = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rx_valid,
  input  sc_rx_pkg::char_t         rx_data,
  input  logic                     rx_perr,
  input  logic                     tx_nak,
  input  logic                     proto_t1,
  input  logic [TW-1:0]            pe_thresh,
  input  logic [LW-1:0]            len_sel,
  input  logic                     rd_en,
  input  logic                     stat_clr,
  output sc_rx_pkg::char_t         rd_data,
  output logic                     pe_flag,
  output logic                     ovr_flag,
  output logic                     full,
  output logic                     not_empty
);
  import sc_rx_pkg::*;

  logic          push, wr_en, rd_go, ovr_evt;
  logic [AW-1:0] waddr, raddr;

  // character mode drops a bad-parity character so the card can repeat it
  assign push = rx_valid && !(rx_perr && (proto_e'(proto_t1) == PROTO_T0));

  sc_rx_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .pop_req (rd_en),
    .len_sel (len_sel),
    .wr_en   (wr_en),
    .waddr   (waddr),
    .rd_go   (rd_go),
    .raddr   (raddr),
    .ovr_evt (ovr_evt),
    .full_q  (full),
    .ne_q    (not_empty)
  );

  sc_rx_mem #(.DW(CHAR_W), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (waddr),
    .wdata (rx_data),
    .re    (rd_go),
    .raddr (raddr),
    .rdata (rd_data)
  );

  sc_rx_perr #(.TW(TW)) u_perr (
    .clk      (clk),
    .rst      (rst),
    .proto_t1 (proto_t1),
    .rx_valid (rx_valid),
    .rx_perr  (rx_perr),
    .tx_nak   (tx_nak),
    .thresh   (pe_thresh),
    .clr      (stat_clr),
    .pe_q     (pe_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)          ovr_flag <= 1'b0;
    else if (ovr_evt) ovr_flag <= 1'b1;
    else if (stat_clr) ovr_flag <= 1'b0;
  end

  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && full && !rx_perr) |=> ovr_flag);

  // R11
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !stat_clr) |=> ovr_flag);

  // R5
  t0_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_perr && !proto_t1 && !rd_en) |=> $stable(not_empty));
endmodule

// File: tb/sc_rx_fifo_bench.sv
module sc_rx_fifo_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0, rx_perr = 1'b0, tx_nak = 1'b0;
  logic       proto_t1 = 1'b0, rd_en = 1'b0, stat_clr = 1'b0;
  logic [7:0] rx_data = '0;
  logic [2:0] pe_thresh = '0, len_sel = 3'd7;
  logic [7:0] rd_data;
  logic       pe_flag, ovr_flag, full, not_empty;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  sc_rx_fifo u_sc_rx_fifo (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .tx_nak(tx_nak), .proto_t1(proto_t1),
    .pe_thresh(pe_thresh), .len_sel(len_sel), .rd_en(rd_en),
    .stat_clr(stat_clr), .rd_data(rd_data), .pe_flag(pe_flag),
    .ovr_flag(ovr_flag), .full(full), .not_empty(not_empty)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // driver: one character strobe; pushes expected value when it should be stored
  task automatic send(input logic [7:0] d, input logic perr, input logic expect_store);
    rx_data = d; rx_perr = perr; rx_valid = 1'b1;
    cyc();
    rx_valid = 1'b0; rx_perr = 1'b0;
    if (expect_store) exp_q.push_back(d);
  endtask

  // monitor: read one character and compare against the scoreboard head
  task automatic pop_check(input string req);
    logic [7:0] e;
    rd_en = 1'b1;
    cyc();
    rd_en = 1'b0;
    e = exp_q.pop_front();
    chk(rd_data == e, req, rd_data, e);
  endtask

  task automatic clear_flags();
    stat_clr = 1'b1; cyc(); stat_clr = 1'b0;
  endtask

  task automatic nak();
    tx_nak = 1'b1; cyc(); tx_nak = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk(not_empty == 0, "R1 not_empty", not_empty, 0);
    chk(full == 0, "R1 full", full, 0);
    chk(pe_flag == 0, "R1 pe_flag", pe_flag, 0);
    chk(ovr_flag == 0, "R1 ovr_flag", ovr_flag, 0);

    // R3 depth 4, R4 overrun
    len_sel = 3'd3; cyc();
    send(8'h11, 0, 1); send(8'h22, 0, 1); send(8'h33, 0, 1);
    chk(full == 0, "R3 not yet full", full, 0);
    send(8'h44, 0, 1);
    chk(full == 1, "R3 full at len+1", full, 1);
    send(8'hE0, 1, 0);
    chk(ovr_flag == 0, "R4 parity drop no overrun", ovr_flag, 0);
    send(8'h55, 0, 0);
    chk(ovr_flag == 1, "R4 overrun set", ovr_flag, 1);
    cyc(); cyc();
    chk(ovr_flag == 1, "R11 overrun sticky", ovr_flag, 1);
    // R2 order
    pop_check("R2 order"); pop_check("R2 order");
    pop_check("R2 order"); pop_check("R4 contents kept");
    chk(not_empty == 0, "R2 empty after reads", not_empty, 0);
    rd_en = 1'b1; cyc(); rd_en = 1'b0;
    chk(rd_data == 8'h44, "R2 empty read ignored", rd_data, 8'h44);
    chk(not_empty == 0, "R2 empty read state", not_empty, 0);
    clear_flags();
    chk(ovr_flag == 0, "R9 overrun cleared", ovr_flag, 0);

    // R5, R6 in T=0 with threshold 2
    pe_thresh = 3'd2; cyc();
    send(8'hA1, 1, 0);
    chk(not_empty == 0, "R5 errored char dropped", not_empty, 0);
    chk(pe_flag == 0, "R6 below threshold", pe_flag, 0);
    send(8'hA2, 1, 0);
    chk(pe_flag == 1, "R6 threshold reached", pe_flag, 1);
    send(8'h5A, 0, 1);
    pop_check("R5 clean char stored");
    clear_flags();
    chk(pe_flag == 0, "R9 pe cleared", pe_flag, 0);

    // R7 NAK in T=0
    nak();
    chk(pe_flag == 1, "R7 nak sets pe", pe_flag, 1);
    clear_flags();

    // R10 mode change clears count
    send(8'hB1, 1, 0);
    proto_t1 = 1'b1; cyc(); proto_t1 = 1'b0; cyc();
    send(8'hB2, 1, 0);
    chk(pe_flag == 0, "R10 count cleared by mode change", pe_flag, 0);
    send(8'hB3, 1, 0);
    chk(pe_flag == 1, "R10 count resumes", pe_flag, 1);
    clear_flags();

    // R8 T=1 stores errored chars, no pe; R7 nak ignored
    proto_t1 = 1'b1; pe_thresh = 3'd1; cyc();
    send(8'hC1, 1, 1); send(8'hC2, 1, 1); send(8'hC3, 1, 1);
    chk(pe_flag == 0, "R8 no pe in T=1", pe_flag, 0);
    nak();
    chk(pe_flag == 0, "R7 nak ignored in T=1", pe_flag, 0);
    pop_check("R8 errored char stored");
    pop_check("R8 errored char stored");
    pop_check("R8 errored char stored");

    // R6 threshold 0 means 8
    proto_t1 = 1'b0; pe_thresh = 3'd0; cyc();
    for (int i = 0; i < 7; i++) send(8'(i), 1, 0);
    chk(pe_flag == 0, "R6 seven errors below eight", pe_flag, 0);
    send(8'hF8, 1, 0);
    chk(pe_flag == 1, "R6 eighth error", pe_flag, 1);
    clear_flags();

    // R3 depth 1
    len_sel = 3'd0; cyc();
    send(8'h77, 0, 1);
    chk(full == 1, "R3 depth one full", full, 1);
    send(8'h78, 0, 0);
    chk(ovr_flag == 1, "R4 overrun depth one", ovr_flag, 1);
    pop_check("R3 depth one data");
    chk(full == 0, "R3 full drops after read", full, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule